// File: doc/BRIEF.md
# Isochronous SYT Timestamp Generator

This block computes the 16-bit presentation timestamp (SYT) that travels in each outgoing isochronous audio packet. It runs once per bus cycle: on every cycle strobe it advances an internal offset, counted in 24.576 MHz ticks against a 3072-tick cycle. From that offset it decides whether a sample-group boundary lands in the coming cycle. If one does, it emits a timestamp made of a 4-bit cycle field and a 12-bit tick field. If none does, it emits the no-information value 0xFFFF.

A start pulse captures the sample-rate code and the blocking-mode bit and resets the offset state. After that, each strobe carries the current seconds count and cycle number. The block looks 48 cycles ahead of the completion cycle it is given, adds a transfer delay that depends on the rate and the mode, and then splits the delayed offset into whole cycles and remaining ticks. For the 44.1 kHz family, a 147-phase step sequence of 1386 or 1387 ticks keeps the rounded timestamps exact over the long run.

Top module: `syt_timestamp_gen`

## Requirements
- R1: After reset, `syt_vld_o` is 0 and `syt_o` is 0xFFFF. Cycle strobes that arrive before the first start pulse produce no valid pulse.
- R2: Once started, each cycle strobe gives exactly one `syt_vld_o` pulse, one clock wide, on the clock after the strobe. A start pulse in the same clock as a strobe takes priority, and that strobe gives no pulse.
- R3: On a strobe, an offset of 3072 or more is reduced by 3072 and the phase is not stepped. An offset below 3072 has the rate step added. If the resulting offset is 3072 or more, the output is 0xFFFF.
- R4: Rate codes are 0=32 kHz, 1=44.1, 2=48, 3=88.2, 4=96, 5=176.4 and 6=192 kHz. The step is 3072 ticks for code 0 and 1024 ticks for codes 2, 4 and 6.
- R5: Codes 1, 3 and 5 use a phase that starts at 67. Each step is 1386 ticks, plus 1 when (phase mod 13 is nonzero and divisible by 4) or when the phase is 146. The phase then advances and wraps from 146 to 0.
- R6: With a new offset `o` below 3072 and a delay `D`, let `t = o + D`. Then SYT = ((count + t div 3072) << 12) + (t mod 3072), truncated to 16 bits.
- R7: In non-blocking mode, D is 8704 ticks.
- R8: In blocking mode, D is 8704 plus 6144 at 32 kHz, plus 4458 for the 44.1 kHz family, and plus 4096 for 48, 96 and 192 kHz.
- R9: The count is seconds×8000 + cycle + 48, wrapped modulo 64000.
- R10: The rate and mode inputs take effect only at a start pulse. Changing them afterwards has no effect on the outputs.
- R11: A start pulse during a running stream sets the offset back to 3072 and the phase back to 67. The outputs that follow match a fresh stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; captures rate and mode, resets offset state |
| rate_i | input | 3 | Sample-rate code |
| blocking_i | input | 1 | Blocking transmission mode |
| cyc_stb_i | input | 1 | One pulse per bus cycle |
| cyc_num_i | input | 13 | Cycle number within the second (0–7999) |
| cyc_sec_i | input | 3 | Low bits of the seconds count |
| syt_o | output | 16 | Timestamp, or 0xFFFF for no information |
| syt_vld_o | output | 1 | One-clock pulse marking a new `syt_o` |

## Verification
The bench builds the block with its default parameters: 3072 ticks per cycle, 8000 cycles per second, 3 seconds bits, a look-ahead of 48 cycles and a base delay of 8704 ticks. With these values the 64000-cycle wrap can be reached by starting the cycle count in the last second, just under 48 cycles before its end. A run of about 400 strobes at 44.1 kHz passes through the whole 147-phase sequence and its wrap. The blocking delays of up to 14848 ticks drive the cycle-and-tick split to a quotient of five.

// File: rtl/syt_gen_pkg.sv
package syt_gen_pkg;

    typedef enum logic [2:0] {
        RATE_32K   = 3'd0,
        RATE_44K1  = 3'd1,
        RATE_48K   = 3'd2,
        RATE_88K2  = 3'd3,
        RATE_96K   = 3'd4,
        RATE_176K4 = 3'd5,
        RATE_192K  = 3'd6
    } rate_e;

    localparam int unsigned CYC_TICKS   = 3072;
    localparam int unsigned PHASE_LEN   = 147;
    localparam int unsigned PHASE_INIT  = 67;
    localparam int unsigned STEP44_BASE = 1386;
    localparam int unsigned MAX_EXTRA   = 6144;

    // 44.1 kHz family: rates that need the fractional step sequence
    function automatic logic is_fam44(rate_e r);
        return (r == RATE_44K1) || (r == RATE_88K2) || (r == RATE_176K4);
    endfunction

    // integer-ratio rates: fixed tick step per cycle
    function automatic int unsigned fixed_step(rate_e r);
        return (r == RATE_32K) ? CYC_TICKS : 1024;
    endfunction

    // extra blocking-mode buffering: ticks spanned by one sample group
    function automatic int unsigned blocking_extra(rate_e r);
        if (r == RATE_32K)
            return MAX_EXTRA;
        else if (is_fam44(r))
            return 4458;
        else
            return 4096;
    endfunction

endpackage

// File: rtl/syt_step_gen.sv
module syt_step_gen
    import syt_gen_pkg::*;
#(
    parameter int OFF_W = 13,
    parameter int PH_W  = 8
) (
    input  rate_e             rate,
    input  logic [PH_W-1:0]   phase,
    output logic [OFF_W-1:0]  step,
    output logic [PH_W-1:0]   phase_nxt
);
    logic [3:0] idx;
    logic       bump;

    always_comb begin
        idx  = 4'(phase % PH_W'(13));
        bump = ((idx != 4'd0) && (idx[1:0] == 2'b00)) ||
               (phase == PH_W'(PHASE_LEN - 1));
        if (is_fam44(rate)) begin
            step      = OFF_W'(STEP44_BASE) + OFF_W'(bump);
            phase_nxt = (phase == PH_W'(PHASE_LEN - 1)) ? '0 : phase + PH_W'(1);
        end else begin
            step      = OFF_W'(fixed_step(rate));
            phase_nxt = phase;
        end
    end
endmodule

// File: rtl/syt_delay_split.sv
module syt_delay_split #(
    parameter int DLY_W   = 15,
    parameter int TPC     = 3072,
    parameter int QSTAGES = 5,
    parameter int QW      = 3
) (
    input  logic [DLY_W-1:0] total,
    output logic [QW-1:0]    quot,
    output logic [DLY_W-1:0] rem
);
    logic [DLY_W-1:0] r_s [0:QSTAGES];
    logic [QW-1:0]    q_s [0:QSTAGES];

    assign r_s[0] = total;
    assign q_s[0] = '0;

    for (genvar i = 0; i < QSTAGES; i++) begin : g_stage
        logic take;
        assign take       = (r_s[i] >= DLY_W'(TPC));
        assign r_s[i+1]   = take ? (r_s[i] - DLY_W'(TPC)) : r_s[i];
        assign q_s[i+1]   = q_s[i] + QW'(take);
    end

    assign quot = q_s[QSTAGES];
    assign rem  = r_s[QSTAGES];
endmodule

// File: rtl/syt_cycle_calc.sv
module syt_cycle_calc #(
    parameter int CYC_W       = 13,
    parameter int SEC_W       = 3,
    parameter int CYC_PER_SEC = 8000,
    parameter int AHEAD       = 48,
    parameter int CNT_W       = 16
) (
    input  logic [SEC_W-1:0] sec,
    input  logic [CYC_W-1:0] cyc,
    output logic [CNT_W-1:0] cnt
);
    localparam int SPAN = CYC_PER_SEC << SEC_W;

    logic [CNT_W:0] sum;

    always_comb begin
        sum = (CNT_W+1)'(sec) * (CNT_W+1)'(CYC_PER_SEC)
            + (CNT_W+1)'(cyc) + (CNT_W+1)'(AHEAD);
        cnt = (sum >= (CNT_W+1)'(SPAN)) ? CNT_W'(sum - (CNT_W+1)'(SPAN))
                                        : CNT_W'(sum);
    end
endmodule

// File: rtl/syt_timestamp_gen.sv
module syt_timestamp_gen
    import syt_gen_pkg::*;
#(
    parameter int TPC         = 3072,
    parameter int CYC_W       = 13,
    parameter int SEC_W       = 3,
    parameter int CYC_PER_SEC = 8000,
    parameter int AHEAD       = 48,
    parameter int BASE_DELAY  = 8704,
    parameter int SYT_W       = 16,
    parameter int FRAC_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       rate_i,
    input  logic             blocking_i,
    input  logic             cyc_stb_i,
    input  logic [CYC_W-1:0] cyc_num_i,
    input  logic [SEC_W-1:0] cyc_sec_i,
    output logic [SYT_W-1:0] syt_o,
    output logic             syt_vld_o
);
    localparam int OFF_W   = $clog2(2 * TPC);
    localparam int MAX_DLY = BASE_DELAY + int'(MAX_EXTRA);
    localparam int DLY_W   = $clog2(2 * TPC + MAX_DLY);
    localparam int QSTAGES = (TPC - 1 + MAX_DLY) / TPC;
    localparam int QW      = $clog2(QSTAGES + 1);
    localparam int CNT_W   = $clog2(CYC_PER_SEC << SEC_W);
    localparam int PH_W    = $clog2(PHASE_LEN);

    typedef struct packed {
        logic             running;
        rate_e            rate;
        logic             blk;
        logic [OFF_W-1:0] off;
        logic [PH_W-1:0]  phase;
        logic [SYT_W-1:0] syt;
        logic             vld;
    } state_t;

    state_t st_d, st_q;

    logic [OFF_W-1:0] step;
    logic [PH_W-1:0]  phase_nxt;
    logic [OFF_W-1:0] off_new;
    logic [DLY_W-1:0] delay;
    logic [DLY_W-1:0] total;
    logic [QW-1:0]    quot;
    logic [DLY_W-1:0] rem;
    logic [CNT_W-1:0] cnt;

    syt_step_gen #(.OFF_W(OFF_W), .PH_W(PH_W)) u_step (
        .rate      (st_q.rate),
        .phase     (st_q.phase),
        .step      (step),
        .phase_nxt (phase_nxt)
    );

    syt_cycle_calc #(
        .CYC_W(CYC_W), .SEC_W(SEC_W), .CYC_PER_SEC(CYC_PER_SEC),
        .AHEAD(AHEAD), .CNT_W(CNT_W)
    ) u_cyc (
        .sec (cyc_sec_i),
        .cyc (cyc_num_i),
        .cnt (cnt)
    );

    syt_delay_split #(
        .DLY_W(DLY_W), .TPC(TPC), .QSTAGES(QSTAGES), .QW(QW)
    ) u_split (
        .total (total),
        .quot  (quot),
        .rem   (rem)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;

        off_new = (st_q.off < OFF_W'(TPC)) ? (st_q.off + step)
                                           : (st_q.off - OFF_W'(TPC));
        delay   = DLY_W'(BASE_DELAY) +
                  (st_q.blk ? DLY_W'(blocking_extra(st_q.rate)) : '0);
        total   = DLY_W'(off_new) + delay;

        if (start_i) begin
            st_d.running = 1'b1;
            st_d.rate    = rate_e'(rate_i);
            st_d.blk     = blocking_i;
            st_d.off     = OFF_W'(TPC);
            st_d.phase   = PH_W'(PHASE_INIT);
        end else if (cyc_stb_i && st_q.running) begin
            st_d.vld = 1'b1;
            st_d.off = off_new;
            if (st_q.off < OFF_W'(TPC))
                st_d.phase = phase_nxt;
            if (off_new < OFF_W'(TPC))
                st_d.syt = SYT_W'(((CNT_W+FRAC_W+1)'(cnt) + (CNT_W+FRAC_W+1)'(quot))
                                  << FRAC_W)
                         + SYT_W'(rem);
            else
                st_d.syt = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.running <= 1'b0;
            st_q.rate    <= RATE_48K;
            st_q.blk     <= 1'b0;
            st_q.off     <= OFF_W'(TPC);
            st_q.phase   <= PH_W'(PHASE_INIT);
            st_q.syt     <= '1;
            st_q.vld     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign syt_o     = st_q.syt;
    assign syt_vld_o = st_q.vld;

    // R2
    vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb_i && st_q.running && !start_i) |=> syt_vld_o);

    // R2
    no_vld_without_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syt_vld_o |-> $past(cyc_stb_i));

    // R11
    start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.off == OFF_W'(TPC) && st_q.phase == PH_W'(PHASE_INIT)));

    // R5
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase < PH_W'(PHASE_LEN));

    // R3
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.off < OFF_W'(2 * TPC));

    // R3
    skip_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb_i && st_q.running && !start_i && st_q.off >= OFF_W'(TPC))
        |=> $stable(st_q.phase));

    // R6
    frac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (syt_vld_o && syt_o != '1) |-> (syt_o[FRAC_W-1:0] < FRAC_W'(TPC)));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.running && !start_i) |=> ($stable(st_q.rate) && $stable(st_q.blk)));

endmodule

// File: tb/sim_syt_timestamp_gen.sv
module sim_syt_timestamp_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  rate_i = 3'd2;
    logic        blocking_i = 1'b0;
    logic        cyc_stb_i = 1'b0;
    logic [12:0] cyc_num_i = '0;
    logic [2:0]  cyc_sec_i = '0;
    logic [15:0] syt_o;
    logic        syt_vld_o;

    int total = 0;
    int bad = 0;

    int m_off, m_phase, m_rate, m_blk, m_run;
    int cur_sec, cur_cyc;

    always #4 clk = ~clk;

    syt_timestamp_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_i(rate_i),
        .blocking_i(blocking_i), .cyc_stb_i(cyc_stb_i), .cyc_num_i(cyc_num_i),
        .cyc_sec_i(cyc_sec_i), .syt_o(syt_o), .syt_vld_o(syt_vld_o)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int rate_hz(int r);
        case (r)
            0: return 32000;  1: return 44100;  2: return 48000;
            3: return 88200;  4: return 96000;  5: return 176400;
            default: return 192000;
        endcase
    endfunction

    function automatic int grp(int r);
        if (r <= 2) return 8;
        if (r <= 4) return 16;
        return 32;
    endfunction

    function automatic bit fam44(int r);
        return (r == 1) || (r == 3) || (r == 5);
    endfunction

    function automatic int model_delay();
        return 8704 + (m_blk ? (24576000 * grp(m_rate)) / rate_hz(m_rate) : 0);
    endfunction

    function automatic int model_next();
        int step, cnt, t, ix;
        if (m_off < 3072) begin
            if (fam44(m_rate)) begin
                ix = m_phase % 13;
                step = 1386 + (((ix != 0) && (ix % 4 == 0)) || (m_phase == 146) ? 1 : 0);
                m_phase = (m_phase + 1) % 147;
            end else begin
                step = (m_rate == 0) ? 3072 : 1024;
            end
            m_off += step;
        end else begin
            m_off -= 3072;
        end
        if (m_off >= 3072) return 16'hFFFF;
        cnt = (cur_sec * 8000 + cur_cyc + 48) % 64000;
        t = m_off + model_delay();
        return (((cnt + t / 3072) << 12) + (t % 3072)) & 16'hFFFF;
    endfunction

    task automatic do_start(int r, int b);
        @(negedge clk);
        start_i = 1'b1; rate_i = 3'(r); blocking_i = b[0];
        @(negedge clk);
        start_i = 1'b0;
        m_off = 3072; m_phase = 67; m_rate = r; m_blk = b; m_run = 1;
    endtask

    task automatic strobe(string req);
        int exp;
        @(negedge clk);
        cyc_stb_i = 1'b1; cyc_num_i = 13'(cur_cyc); cyc_sec_i = 3'(cur_sec);
        @(negedge clk);
        cyc_stb_i = 1'b0;
        exp = m_run ? model_next() : 16'hFFFF;
        chk(syt_vld_o == m_run[0], {req, " vld"}, int'(syt_vld_o), m_run);
        if (m_run) chk(syt_o == 16'(exp), {req, " syt"}, int'(syt_o), exp);
        @(negedge clk);
        chk(syt_vld_o == 1'b0, "R2 pulse width", int'(syt_vld_o), 0);
        cur_cyc++;
        if (cur_cyc == 8000) begin cur_cyc = 0; cur_sec = (cur_sec + 1) % 8; end
    endtask

    task automatic t_reset();
        chk(syt_vld_o == 1'b0, "R1 reset vld", int'(syt_vld_o), 0);
        chk(syt_o == 16'hFFFF, "R1 reset syt", int'(syt_o), 16'hFFFF);
        m_run = 0;
        strobe("R1 before start");
        strobe("R1 before start");
    endtask

    task automatic t_run(int r, int b, int n, string req);
        do_start(r, b);
        for (int i = 0; i < n; i++) strobe(req);
    endtask

    task automatic t_wrap();
        cur_sec = 7; cur_cyc = 7940;
        do_start(2, 0);
        for (int i = 0; i < 20; i++) strobe("R9 count wrap");
    endtask

    task automatic t_cfg_hold();
        do_start(1, 0);
        for (int i = 0; i < 6; i++) strobe("R10 before change");
        rate_i = 3'd0; blocking_i = 1'b1;
        for (int i = 0; i < 12; i++) strobe("R10 inputs changed");
    endtask

    task automatic t_restart();
        do_start(4, 1);
        for (int i = 0; i < 7; i++) strobe("R11 first run");
        @(negedge clk);
        start_i = 1'b1; cyc_stb_i = 1'b1; rate_i = 3'd5; blocking_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; cyc_stb_i = 1'b0;
        chk(syt_vld_o == 1'b0, "R2 start beats strobe", int'(syt_vld_o), 0);
        m_off = 3072; m_phase = 67; m_rate = 5; m_blk = 0; m_run = 1;
        for (int i = 0; i < 10; i++) strobe("R11 after restart");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_sec = 0; cur_cyc = 100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run(2, 0, 12, "R3 R6 R7 48k");
        t_run(0, 0, 8, "R4 32k step");
        t_run(6, 0, 8, "R4 192k step");
        t_run(1, 0, 400, "R5 44.1k phase");
        t_run(3, 0, 40, "R5 88.2k phase");
        t_run(0, 1, 10, "R8 32k blocking");
        t_run(3, 1, 40, "R8 88.2k blocking");
        t_run(6, 1, 16, "R8 192k blocking");
        t_wrap();
        t_cfg_hold();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule